// File: doc/BRIEF.md
# Windowed Trigger Watchdog with Fault Counter

This block watches a trigger pin driven by a host processor. After each reset pulse it ends, the host must toggle the pin within a start-up window. After that, every new toggle must land inside a window that has both a lower and an upper bound, measured from the previous toggle. A toggle that comes too early, comes too late or never comes is a fault. On a fault the block raises a reset pulse whose width is picked by a two-bit select. It also sets a sticky status flag and adds one to a fault counter.

When the counter reaches its limit, the default being five, the block issues no further reset. It drops the power-enable output and parks in a standby state. It stays there until the surrounding mode logic signals a new entry into run mode. That entry clears the counter, restores power-enable and starts a fresh reset pulse. All timing runs on a slow tick enable, nominally 32.768 kHz, inside a faster system clock. The trigger pin is synchronized on the way in.

Top module: `wdog_window`

## Requirements
- R1: After reset, rst_pulse is 0, pwr_en is 1, err_cnt is 0 and wd_status is 0.
- R2: Once a reset pulse ends, the first trigger edge is accepted if it is seen no later than FIRST_TICKS ticks after the pulse ends. An edge seen in the same cycle as the deadline tick wins. With no edge by then, a fault occurs.
- R3: In the running phase, a trigger edge seen fewer than MIN_TICKS ticks after the previous accepted edge is a fault. An edge at exactly MIN_TICKS is accepted.
- R4: In the running phase, reaching MAX_TICKS ticks without a trigger edge is a fault. An edge at exactly MAX_TICKS is accepted.
- R5: A rising edge and a falling edge of wd_pin both count as trigger edges.
- R6: A reset pulse is rst_pulse high for a number of ticks chosen by pulse_sel: 00 gives W20_TICKS, 01 gives W10_TICKS, 10 gives W5_TICKS and 11 gives W1_TICKS. Trigger edges during the pulse are ignored.
- R7: Each fault adds one to err_cnt and sets wd_status. An accepted trigger edge does not lower err_cnt.
- R8: The fault that brings err_cnt to FAULT_LIMIT produces no pulse. Instead pwr_en goes to 0 and stays there, with no pulses and with trigger edges ignored, until run_entry.
- R9: A run_entry pulse clears err_cnt, sets pwr_en to 1 and starts a reset pulse.
- R10: While wd_en is 0 outside standby, no fault is raised, no pulse is produced and err_cnt holds. Raising wd_en starts a new start-up window.
- R11: err_clr sets err_cnt to 0, and status_clr sets wd_status to 0.
- R12: The window and pulse timers advance only on cycles where tick is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase enable, one cycle per slow tick |
| wd_pin | input | 1 | Asynchronous trigger pin from the host |
| wd_en | input | 1 | Watchdog enable from the mode logic |
| run_entry | input | 1 | One-cycle pulse marking entry into run mode |
| err_clr | input | 1 | One-cycle pulse clearing the fault counter |
| status_clr | input | 1 | One-cycle pulse clearing the status flag |
| pulse_sel | input | 2 | Reset pulse width select |
| rst_pulse | output | 1 | Reset pulse to the host, active high |
| pwr_en | output | 1 | Power enable, low in forced standby |
| wd_status | output | 1 | Sticky flag set by a watchdog fault |
| err_cnt | output | $clog2(FAULT_LIMIT+1) | Fault counter |

## Verification
The assertions assume that run_entry, err_clr and status_clr are single-cycle pulses. They also assume that status_clr never lands in the same cycle as a fault, and that a clear never lands in the same cycle as the counter's own increment. The bench drives every input on the falling clock edge. It issues the clears only at points where the window timer is far from any deadline, so a fault and a clear never coincide. The trigger pin is treated as asynchronous, and every expected edge position in the bench includes the fixed three-cycle synchronizer and edge-detect latency.

// File: rtl/wdog_window.sv
`timescale 1ns/1ps
module wdog_window #(
  parameter int FIRST_TICKS = 16384,
  parameter int MIN_TICKS   = 6554,
  parameter int MAX_TICKS   = 9830,
  parameter int W20_TICKS   = 655,
  parameter int W10_TICKS   = 328,
  parameter int W5_TICKS    = 164,
  parameter int W1_TICKS    = 33,
  parameter int FAULT_LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic wd_pin,
  input  logic wd_en,
  input  logic run_entry,
  input  logic err_clr,
  input  logic status_clr,
  input  logic [1:0] pulse_sel,
  output logic rst_pulse,
  output logic pwr_en,
  output logic wd_status,
  output logic [$clog2(FAULT_LIMIT+1)-1:0] err_cnt
);
  localparam int TW = $clog2(FIRST_TICKS + MAX_TICKS + W20_TICKS + 2);
  localparam int CW = $clog2(FAULT_LIMIT + 1);

  typedef enum logic [2:0] {S_IDLE, S_PULSE, S_FIRST, S_RUN, S_STBY} st_t;

  st_t           state;
  logic [TW-1:0] timer;
  logic [TW-1:0] width_m1;
  logic [2:0]    sync_q;
  logic          trig;
  logic          fault;
  logic [CW-1:0] cnt_inc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], wd_pin};

  assign trig = sync_q[2] ^ sync_q[1];

  always_comb
    case (pulse_sel)
      2'b00:   width_m1 = TW'(W20_TICKS - 1);
      2'b01:   width_m1 = TW'(W10_TICKS - 1);
      2'b10:   width_m1 = TW'(W5_TICKS - 1);
      default: width_m1 = TW'(W1_TICKS - 1);
    endcase

  assign fault = wd_en && (
      (state == S_FIRST && !trig && tick && timer == TW'(FIRST_TICKS)) ||
      (state == S_RUN && trig && timer < TW'(MIN_TICKS)) ||
      (state == S_RUN && !trig && tick && timer == TW'(MAX_TICKS)));

  assign cnt_inc   = err_cnt + CW'(1);
  assign rst_pulse = (state == S_PULSE);
  assign pwr_en    = (state != S_STBY);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE;
      timer <= '0;
    end else if (run_entry) begin
      state <= S_PULSE;
      timer <= '0;
    end else if (state == S_STBY) begin
      timer <= '0;
    end else if (!wd_en) begin
      state <= S_IDLE;
      timer <= '0;
    end else if (fault) begin
      state <= (cnt_inc == CW'(FAULT_LIMIT)) ? S_STBY : S_PULSE;
      timer <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          state <= S_FIRST;
          timer <= TW'(1);
        end
        S_PULSE:
          if (tick) begin
            if (timer == width_m1) begin
              state <= S_FIRST;
              timer <= TW'(1);
            end else begin
              timer <= timer + TW'(1);
            end
          end
        S_FIRST, S_RUN:
          if (trig) begin
            state <= S_RUN;
            timer <= TW'(1);
          end else if (tick) begin
            timer <= timer + TW'(1);
          end
        default: state <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   err_cnt <= '0;
    else if (run_entry || err_clr) err_cnt <= '0;
    else if (fault)               err_cnt <= cnt_inc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          wd_status <= 1'b0;
    else if (status_clr) wd_status <= 1'b0;
    else if (fault)      wd_status <= 1'b1;
endmodule

// File: rtl/wdog_window_chk.sv
`timescale 1ns/1ps
module wdog_window_chk #(
  parameter int FAULT_LIMIT = 5
) (
  input logic clk,
  input logic rst_n,
  input logic wd_en,
  input logic run_entry,
  input logic err_clr,
  input logic status_clr,
  input logic rst_pulse,
  input logic pwr_en,
  input logic wd_status,
  input logic [$clog2(FAULT_LIMIT+1)-1:0] err_cnt
);
  assert_standby_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> !rst_pulse);

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= ($clog2(FAULT_LIMIT+1))'(FAULT_LIMIT));

  assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(run_entry) && !$past(err_clr)) |->
      (err_cnt == $past(err_cnt) || err_cnt == $past(err_cnt) + 1'b1));

  assert_off_at_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> err_cnt == ($clog2(FAULT_LIMIT+1))'(FAULT_LIMIT));

  assert_run_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run_entry) |-> (err_cnt == '0 && pwr_en && rst_pulse));

  assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wd_en) && !$past(run_entry)) |-> !rst_pulse);

  assert_status_on_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_pulse) && !$past(run_entry) && !$past(status_clr)) |-> wd_status);
endmodule

bind wdog_window wdog_window_chk #(.FAULT_LIMIT(FAULT_LIMIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .run_entry(run_entry),
  .err_clr(err_clr), .status_clr(status_clr), .rst_pulse(rst_pulse),
  .pwr_en(pwr_en), .wd_status(wd_status), .err_cnt(err_cnt)
);

// File: tb/wdog_window_tb_top.sv
`timescale 1ns/1ps
module wdog_window_tb_top;
  localparam int FIRST = 40, MINT = 16, MAXT = 24, LIM = 5;
  localparam int NV = 7;
  // vector: first edge delay, gap to second edge, expected err_cnt
  localparam int VD[NV] = '{5, 5, 5, 5, 37, 38, 10};
  localparam int VG[NV] = '{16, 15, 24, 25, 20, 10, 20};
  localparam int VE[NV] = '{0, 1, 0, 1, 0, 1, 0};
  localparam int PW[4]  = '{12, 8, 5, 3};

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, wd_pin = 1'b0, wd_en = 1'b1;
  logic run_entry = 1'b0, err_clr = 1'b0, status_clr = 1'b0;
  logic [1:0] pulse_sel = 2'b11;
  logic rst_pulse, pwr_en, wd_status;
  logic [2:0] err_cnt;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_window #(.FIRST_TICKS(FIRST), .MIN_TICKS(MINT), .MAX_TICKS(MAXT),
    .W20_TICKS(12), .W10_TICKS(8), .W5_TICKS(5), .W1_TICKS(3),
    .FAULT_LIMIT(LIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wd_pin(wd_pin), .wd_en(wd_en),
    .run_entry(run_entry), .err_clr(err_clr), .status_clr(status_clr),
    .pulse_sel(pulse_sel), .rst_pulse(rst_pulse), .pwr_en(pwr_en),
    .wd_status(wd_status), .err_cnt(err_cnt));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_run();
    @(negedge clk); run_entry = 1'b1; status_clr = 1'b1;
    @(negedge clk); run_entry = 1'b0; status_clr = 1'b0;
    while (rst_pulse) @(negedge clk);
  endtask

  task automatic count_rises(input int n, output int rises);
    logic prev;
    rises = 0;
    prev = rst_pulse;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rst_pulse && !prev) rises++;
      prev = rst_pulse;
    end
  endtask

  initial begin
    int r, w;
    repeat (3) @(negedge clk);
    check("R1 rst_pulse", rst_pulse, 0);
    check("R1 pwr_en", pwr_en, 1);
    check("R1 err_cnt", err_cnt, 0);
    check("R1 wd_status", wd_status, 0);
    rst_n = 1'b1;

    // window vectors; toggles alternate polarity (R5)
    for (int v = 0; v < NV; v++) begin
      start_run();
      repeat (VD[v]) @(negedge clk);
      wd_pin = ~wd_pin;
      repeat (VG[v]) @(negedge clk);
      wd_pin = ~wd_pin;
      repeat (6) @(negedge clk);
      check($sformatf("R2/R3/R4/R5 vec%0d err_cnt", v), err_cnt, VE[v]);
      check($sformatf("R7 vec%0d wd_status", v), wd_status, VE[v]);
    end

    // R6 pulse widths after run_entry
    for (int s = 0; s < 4; s++) begin
      pulse_sel = 2'(s);
      @(negedge clk); run_entry = 1'b1;
      @(negedge clk); run_entry = 1'b0;
      w = 0;
      while (rst_pulse) begin w++; @(negedge clk); end
      check($sformatf("R6 width sel=%0d", s), w, PW[s]);
    end

    // R6/R2 fault pulse after missing first edge, sel 00
    pulse_sel = 2'b00;
    start_run();
    w = 0;
    while (!rst_pulse && w < 100) begin w++; @(negedge clk); end
    check("R2 late first fault position", w, FIRST);
    w = 0;
    while (rst_pulse) begin w++; @(negedge clk); end
    check("R6 fault pulse width", w, 12);
    check("R7 err_cnt after fault", err_cnt, 1);

    // R11 clears
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    check("R11 err_clr", err_cnt, 0);
    @(negedge clk); status_clr = 1'b1;
    @(negedge clk); status_clr = 1'b0;
    check("R11 status_clr", wd_status, 0);

    // R8 standby after five faults
    pulse_sel = 2'b11;
    start_run();
    count_rises(300, r);
    check("R8 pulses before standby", r, LIM - 1);
    check("R8 pwr_en low", pwr_en, 0);
    check("R8 err_cnt at limit", err_cnt, LIM);
    for (int i = 0; i < 4; i++) begin
      repeat (10) @(negedge clk); wd_pin = ~wd_pin;
    end
    count_rises(80, r);
    check("R8 no pulses in standby", r, 0);
    check("R8 pwr_en stays low", pwr_en, 0);

    // R9 leave standby
    start_run();
    check("R9 pwr_en restored", pwr_en, 1);
    check("R9 err_cnt cleared", err_cnt, 0);

    // R10 disable
    @(negedge clk); wd_en = 1'b0;
    count_rises(100, r);
    check("R10 no pulse while disabled", r, 0);
    check("R10 err_cnt held", err_cnt, 0);
    wd_en = 1'b1;
    repeat (50) @(negedge clk);
    check("R10 new window after enable", err_cnt, 1);

    // R12 tick gating
    start_run();
    tick = 1'b0;
    count_rises(100, r);
    check("R12 frozen without tick", r, 0);
    check("R12 err_cnt frozen", err_cnt, 0);
    tick = 1'b1;
    repeat (45) @(negedge clk);
    check("R12 timer resumes", err_cnt, 1);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog timeout actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule